// File: doc/BRIEF.md
# Four-Stage Watchdog Timer

The block is a watchdog that steps through four timeout stages, 0 to 3, and then wraps back to stage 0. Each stage has its own timeout, counted in clock cycles. When a stage expires, the block does what that stage is set to do: nothing, raise an interrupt, send a reset pulse to the CPU, or send a reset pulse to the whole system. Software keeps the watchdog quiet by pulsing `feed` often enough. Each feed sends the sequence back to the start of stage 0.

Software sets the watchdog up through a simple write port. One word holds the global enable, the four stage actions, the interrupt style and the two reset-pulse width codes. Four more words hold the stage timeouts. An interrupt can be a one-cycle pulse, a level that stays high until it is cleared, or both. A system reset pulse returns the watchdog itself to its reset state once the pulse ends. A CPU reset pulse leaves the configuration in place, so the watchdog keeps running.

Top module: `wdog_stages`

## Requirements
- R1: After `rst_n` is low, `irq`, `cpu_rst` and `sys_rst` are low. The control word and all four timeouts are 0, so the watchdog is disabled.
- R2: While the enable bit is 0, the stage counter and stage index stay at 0 and no output goes high, whatever the other settings are.
- R3: The write port is used as follows. Writing to address 0 loads the control word: bit 0 is enable, bits [2*s+2:2*s+1] are the action of stage s, bit 9 enables the edge interrupt, bit 10 enables the level interrupt, bits [13:11] are the CPU pulse code and bits [16:14] are the system pulse code. Writing to address s+1 loads the timeout of stage s. Action codes are 0 = off, 1 = interrupt, 2 = CPU reset, 3 = system reset.
- R4: Stages run in the order 0, 1, 2, 3 and then back to 0. Stage s lasts max(T_s,1) clock cycles. Counted from the clock edge that enables the watchdog or accepts a feed, stage s expires on the max(T_s,1)-th edge after it begins.
- R5: A stage whose action is off still uses up its full timeout before the next stage starts.
- R6: When an interrupt stage expires and the edge enable is set, `irq` goes high for exactly one cycle, starting the cycle after the expiry edge.
- R7: When an interrupt stage expires and the level enable is set, `irq` goes high the cycle after the expiry edge. It stays high until `int_clr` or `feed` is sampled high. A new expiry in the same cycle as a clear wins.
- R8: `feed` clears the counter and returns the sequence to stage 0. The stage that would have expired on that edge takes no action.
- R9: A CPU-reset stage drives `cpu_rst` high for U*UNIT_CYC cycles, starting the cycle after expiry. U is 1, 2, 3, 4, 5, 8, 16 or 32 for code 0 to 7. A new trigger while the pulse is active restarts the width.
- R10: A system-reset stage drives `sys_rst` with the same width table, using its own code. When the pulse ends, the control word and all timeouts return to their reset values.
- R11: A CPU-reset pulse leaves the configuration unchanged, so the sequence keeps running and fires again one full round of stages later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 = control, 1 to 4 = stage timeouts |
| wr_data | input | 32 | Write data |
| feed | input | 1 | Restart strobe |
| int_clr | input | 1 | Clears a pending level interrupt |
| irq | output | 1 | Interrupt (edge pulse or level) |
| cpu_rst | output | 1 | CPU reset pulse |
| sys_rst | output | 1 | System reset pulse |

## Verification
A table of four configurations places the CPU-reset action in a different stage each time and varies the timeout and width code. The measured delay to the first pulse shows whether the stages run in the right order and whether the off stages use up their time. The measured width shows whether each code maps to the right entry of the table. Directed runs cover the remaining cases:
- Edge and level interrupts are set up separately, which separates a one-cycle pulse from a held level.
- Clearing the level with `int_clr` is kept apart from clearing it with a feed.
- A feed stream shows that feeding stops all expiries.
- A system-reset run followed by a re-enable with no timeouts written shows that the configuration was wiped. A second CPU pulse one round later shows that it was not.

// File: rtl/wdog_stages.sv
module wdog_stages #(
  parameter int TW       = 32,
  parameter int UNIT_CYC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          feed,
  input  logic          int_clr,
  output logic          irq,
  output logic          cpu_rst,
  output logic          sys_rst
);
  localparam int PW = $clog2(32 * UNIT_CYC + 1);
  localparam logic [1:0] ACT_INT = 2'd1;
  localparam logic [1:0] ACT_CPU = 2'd2;
  localparam logic [1:0] ACT_SYS = 2'd3;

  logic [16:0]   ctrl;
  logic [TW-1:0] tmo [4];
  logic [TW-1:0] cnt;
  logic [1:0]    stage;
  logic          edge_q, lvl_q;
  logic [PW-1:0] cpu_cnt, sys_cnt;

  wire        en      = ctrl[0];
  wire [7:0]  acts    = ctrl[8:1];
  wire [1:0]  act     = acts[{stage, 1'b0} +: 2];
  wire        edge_en = ctrl[9];
  wire        lvl_en  = ctrl[10];
  wire [2:0]  cpu_code = ctrl[13:11];
  wire [2:0]  sys_code = ctrl[16:14];

  wire        expire  = en && (({1'b0, cnt} + (TW+1)'(1)) >= {1'b0, tmo[stage]});
  wire        fire    = expire && !feed;
  wire        sys_end = en && (sys_cnt == PW'(1));

  function automatic logic [PW-1:0] width_of(input logic [2:0] code);
    int units;
    units = (code < 3'd5) ? int'(code) + 1 : (8 << (int'(code) - 5));
    return PW'(units * UNIT_CYC);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || sys_end) begin
      ctrl <= '0;
      for (int i = 0; i < 4; i++) tmo[i] <= '0;
    end else if (wr_en) begin
      if (wr_addr == 3'd0) ctrl <= wr_data[16:0];
      for (int i = 0; i < 4; i++)
        if (wr_addr == 3'(i + 1)) tmo[i] <= wr_data[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; stage <= '0; edge_q <= 1'b0; lvl_q <= 1'b0;
      cpu_cnt <= '0; sys_cnt <= '0;
    end else if (!en) begin
      cnt <= '0; stage <= '0; edge_q <= 1'b0; lvl_q <= 1'b0;
      cpu_cnt <= '0; sys_cnt <= '0;
    end else begin
      if (feed) begin
        cnt <= '0; stage <= '0;
      end else if (expire) begin
        cnt <= '0; stage <= stage + 2'd1;
      end else begin
        cnt <= cnt + TW'(1);
      end

      edge_q <= fire && (act == ACT_INT) && edge_en;

      if (fire && (act == ACT_INT) && lvl_en) lvl_q <= 1'b1;
      else if (feed || int_clr)               lvl_q <= 1'b0;

      if (fire && (act == ACT_CPU))  cpu_cnt <= width_of(cpu_code);
      else if (cpu_cnt != '0)        cpu_cnt <= cpu_cnt - PW'(1);

      if (fire && (act == ACT_SYS))  sys_cnt <= width_of(sys_code);
      else if (sys_cnt != '0)        sys_cnt <= sys_cnt - PW'(1);
    end
  end

  assign irq     = edge_q | lvl_q;
  assign cpu_rst = cpu_cnt != '0;
  assign sys_rst = sys_cnt != '0;

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!irq && !cpu_rst && !sys_rst));

  assert_stage_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(feed) && stage != $past(stage)) |-> stage == $past(stage) + 2'd1);

  assert_edge_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |-> $past(edge_en && act == ACT_INT && expire));

  assert_feed_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (feed && en) |=> (cnt == '0 && stage == 2'd0));

  assert_cpu_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst) |-> $past(act == ACT_CPU && expire));
endmodule

// File: tb/wdog_stages_test.sv
`timescale 1ns/1ps
module wdog_stages_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic feed = 1'b0;
  logic int_clr = 1'b0;
  logic irq, cpu_rst, sys_rst;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdog_stages #(.TW(32), .UNIT_CYC(5)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .feed(feed), .int_clr(int_clr), .irq(irq), .cpu_rst(cpu_rst), .sys_rst(sys_rst));

  localparam int NV = 4;
  localparam int V_STAGE [NV] = '{0, 2, 3, 1};
  localparam int V_TMO   [NV] = '{10, 20, 50, 30};
  localparam int V_CODE  [NV] = '{0, 5, 7, 6};
  localparam int V_DELAY [NV] = '{10, 60, 200, 60};
  localparam int V_WIDTH [NV] = '{5, 40, 160, 80};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all_tmo(input int t);
    for (int s = 0; s < 4; s++) wr(3'(s + 1), 32'(t));
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, w, seen;
    tick(3);
    chk(!irq && !cpu_rst && !sys_rst, "R1 outputs in reset", {irq, cpu_rst, sys_rst}, 0);
    rst_n = 1'b1;
    tick(2);
    chk(!irq && !cpu_rst && !sys_rst, "R1 outputs after reset", {irq, cpu_rst, sys_rst}, 0);

    // R2: configured but disabled
    set_all_tmo(1);
    wr(3'd0, 32'h0000_0154 | 32'h600);
    seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq || cpu_rst || sys_rst) seen++;
    end
    chk(seen == 0, "R2 disabled stays idle", seen, 0);

    // R3 R4 R5 R9: vector table for stage position, timeout and width code
    for (int v = 0; v < NV; v++) begin
      wr(3'd0, 32'h0);
      tick(2);
      set_all_tmo(V_TMO[v]);
      wr(3'd0, 32'h1 | (32'h2 << (1 + 2 * V_STAGE[v])) | (32'(V_CODE[v]) << 11));
      k = 0;
      while (!cpu_rst && k < 1000) begin @(negedge clk); k++; end
      chk(k == V_DELAY[v], $sformatf("R4 R5 vector %0d delay", v), k, V_DELAY[v]);
      w = 0;
      while (cpu_rst && w < 1000) begin @(negedge clk); w++; end
      chk(w == V_WIDTH[v], $sformatf("R9 vector %0d width", v), w, V_WIDTH[v]);
      if (v == 0) begin
        // R11: config kept, second pulse one round later
        k = k + w;
        while (!cpu_rst && k < 1000) begin @(negedge clk); k++; end
        chk(k == 50, "R11 second cpu pulse", k, 50);
      end
    end

    // R6: edge interrupt
    wr(3'd0, 32'h0); tick(2);
    set_all_tmo(5);
    wr(3'd0, 32'h203);
    tick(4);
    chk(!irq, "R6 irq before expiry", irq, 0);
    tick(1);
    chk(irq, "R6 edge pulse high", irq, 1);
    tick(1);
    chk(!irq, "R6 edge pulse one cycle", irq, 0);

    // R7: level interrupt, cleared by int_clr then by feed
    wr(3'd0, 32'h0); tick(2);
    wr(3'd0, 32'h403);
    tick(5);
    chk(irq, "R7 level set", irq, 1);
    tick(9);
    chk(irq, "R7 level held", irq, 1);
    int_clr = 1'b1; tick(1); int_clr = 1'b0;
    tick(1);
    chk(!irq, "R7 cleared by int_clr", irq, 0);
    tick(9);
    chk(irq, "R7 level set again", irq, 1);
    feed = 1'b1; tick(1); feed = 1'b0;
    chk(!irq, "R7 R8 cleared by feed", irq, 0);
    tick(4);
    chk(!irq, "R8 restart before expiry", irq, 0);
    tick(1);
    chk(irq, "R8 expiry after restart", irq, 1);

    // R8: regular feeding prevents any action
    wr(3'd0, 32'h0); tick(2);
    set_all_tmo(10);
    wr(3'd0, 32'h5);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick(4);
      feed = 1'b1; tick(1); feed = 1'b0;
      if (cpu_rst) seen++;
    end
    chk(seen == 0, "R8 feeding blocks reset", seen, 0);

    // R10: system reset pulse, then self-clear
    wr(3'd0, 32'h0); tick(2);
    wr(3'd0, 32'h4007);
    k = 0;
    while (!sys_rst && k < 1000) begin @(negedge clk); k++; end
    chk(k == 10, "R10 sys pulse delay", k, 10);
    w = 0;
    while (sys_rst && w < 1000) begin @(negedge clk); w++; end
    chk(w == 10, "R10 sys pulse width", w, 10);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sys_rst || cpu_rst || irq) seen++;
    end
    chk(seen == 0, "R10 disabled after sys reset", seen, 0);
    wr(3'd0, 32'h5);
    k = 0;
    while (!cpu_rst && k < 1000) begin @(negedge clk); k++; end
    chk(k == 1, "R10 timeouts cleared", k, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule